// File: doc/BRIEF.md
# Address Quadrant Context Selector

This block works out the translation context for one memory access. It takes a 64-bit effective address, a flag that says whether the processor runs in hypervisor mode, the access kind, and two 64-bit context values: the current partition identifier and the current process identifier. From the two most significant address bits, called the quadrant, it picks the partition and process identifiers that a later table walk must use. It also flags a segment fault when the address is malformed or the quadrant is not allowed.

Each request is a single-cycle strobe. The result appears one clock later together with a response strobe. A segment fault is split into two kinds. A fetch raises the instruction kind. A load or store raises the data kind and also latches the faulting address. Table walking and permission checks are done elsewhere.

Top module: `quadrant_ctx_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every output is zero.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. `part_id`, `proc_id`, `seg_fault`, `iseg_fault` and `dseg_fault` change only at a response; they keep their values between responses.
- R3: If any address bit in positions 61 down to 52 (bit 63 is the most significant) is set, the response has `seg_fault` = 1 and `part_id` = `proc_id` = 0, whatever the mode and quadrant.
- R4: In hypervisor mode (`hv_mode` = 1), quadrant 0 (`ea[63:62]` = 0) gives partition 0 with the current process identifier. Quadrant 1 gives the current partition and the current process identifier.
- R5: In hypervisor mode, quadrant 2 gives the current partition with process 0. Quadrant 3 gives partition 0 with process 0.
- R6: In guest mode (`hv_mode` = 0), quadrant 0 gives the current partition and the current process identifier. Quadrant 3 gives the current partition with process 0.
- R7: In guest mode, quadrants 1 and 2 give `seg_fault` = 1 with both identifiers zero.
- R8: A faulting fetch (`acc_kind` = 2) gives `iseg_fault` = 1 and `dseg_fault` = 0, and leaves `fault_addr` unchanged.
- R9: A faulting load (`acc_kind` = 0) or store (`acc_kind` = 1) gives `dseg_fault` = 1 and `iseg_fault` = 0, and loads `fault_addr` with the request address. The unused code 3 is treated as a data access.
- R10: A response without a fault has `seg_fault`, `iseg_fault` and `dseg_fault` all zero, and `fault_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| hv_mode | input | 1 | 1 = hypervisor mode, 0 = guest mode |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as data |
| cur_part | input | 64 | Current partition identifier |
| cur_proc | input | 64 | Current process identifier |
| rsp_valid | output | 1 | Response strobe |
| part_id | output | 64 | Selected partition identifier |
| proc_id | output | 64 | Selected process identifier |
| seg_fault | output | 1 | Segment fault on this response |
| iseg_fault | output | 1 | Instruction segment fault |
| dseg_fault | output | 1 | Data segment fault |
| fault_addr | output | 64 | Last data-faulting address |

## Verification
The hardest case to reach is a fault in which two causes overlap: a reserved bit set in a quadrant that is also illegal in guest mode, or in a quadrant that hypervisor mode would otherwise accept. The effect must also be visible in `fault_addr` afterwards. Uniformly random addresses almost always set a reserved bit, so the stimulus clears that field most of the time and sets one chosen bit only sometimes. Directed cases then set each edge bit (52 and 61) alone. A fetch fault that follows a data fault checks that the latched address survives it.

// File: rtl/quadrant_ctx_sel.sv
module quadrant_ctx_sel #(
  parameter int AW   = 64,
  parameter int IDW  = 64,
  parameter int RSV_HI = 61,
  parameter int RSV_LO = 52
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  ea,
  input  logic           hv_mode,
  input  logic [1:0]     acc_kind,
  input  logic [IDW-1:0] cur_part,
  input  logic [IDW-1:0] cur_proc,
  output logic           rsp_valid,
  output logic [IDW-1:0] part_id,
  output logic [IDW-1:0] proc_id,
  output logic           seg_fault,
  output logic           iseg_fault,
  output logic           dseg_fault,
  output logic [AW-1:0]  fault_addr
);
  localparam logic [1:0] KIND_FETCH = 2'd2;

  logic [1:0]     quad;
  logic           rsv_bad, quad_bad, fault;
  logic [IDW-1:0] sel_part, sel_proc;

  assign quad     = ea[AW-1 -: 2];
  assign rsv_bad  = |ea[RSV_HI:RSV_LO];
  assign quad_bad = !hv_mode && (quad == 2'd1 || quad == 2'd2);
  assign fault    = rsv_bad || quad_bad;

  always_comb begin
    sel_part = '0;
    sel_proc = '0;
    if (!fault) begin
      if (hv_mode) begin
        unique case (quad)
          2'd0: sel_proc = cur_proc;
          2'd1: begin sel_part = cur_part; sel_proc = cur_proc; end
          2'd2: sel_part = cur_part;
          default: ;
        endcase
      end else begin
        sel_part = cur_part;
        if (quad == 2'd0) sel_proc = cur_proc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      part_id    <= '0;
      proc_id    <= '0;
      seg_fault  <= 1'b0;
      iseg_fault <= 1'b0;
      dseg_fault <= 1'b0;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        part_id    <= sel_part;
        proc_id    <= sel_proc;
        seg_fault  <= fault;
        iseg_fault <= fault && acc_kind == KIND_FETCH;
        dseg_fault <= fault && acc_kind != KIND_FETCH;
        if (fault && acc_kind != KIND_FETCH) fault_addr <= ea;
      end
    end
  end
endmodule

module quadrant_ctx_sel_chk #(
  parameter int AW  = 64,
  parameter int IDW = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [AW-1:0]  ea,
  input logic           rsp_valid,
  input logic [IDW-1:0] part_id,
  input logic [IDW-1:0] proc_id,
  input logic           seg_fault,
  input logic           iseg_fault,
  input logic           dseg_fault,
  input logic [AW-1:0]  fault_addr
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(part_id) && $stable(proc_id) && $stable(seg_fault));
  a_r7_fault_zero_ids: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && seg_fault |-> part_id == '0 && proc_id == '0);
  a_r8_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iseg_fault, dseg_fault}));
  a_r9_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && dseg_fault |-> fault_addr == $past(ea));
  a_r10_clean_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_fault |-> !iseg_fault && !dseg_fault);
  a_r8_fetch_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !dseg_fault |-> $stable(fault_addr));
endmodule

bind quadrant_ctx_sel quadrant_ctx_sel_chk #(.AW(AW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ea(ea),
  .rsp_valid(rsp_valid), .part_id(part_id), .proc_id(proc_id),
  .seg_fault(seg_fault), .iseg_fault(iseg_fault), .dseg_fault(dseg_fault),
  .fault_addr(fault_addr));

// File: tb/tb_quadrant_ctx_sel.sv
module tb_quadrant_ctx_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] ea = '0;
  logic        hv_mode = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [63:0] cur_part = '0;
  logic [63:0] cur_proc = '0;
  logic        rsp_valid, seg_fault, iseg_fault, dseg_fault;
  logic [63:0] part_id, proc_id, fault_addr;

  int checks = 0;
  int failures = 0;
  logic [63:0] model_faddr = '0;

  always #5 clk = ~clk;

  quadrant_ctx_sel dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_fault(logic [63:0] a, logic hv);
    return (|a[61:52]) || (!hv && (a[63:62] == 2'd1 || a[63:62] == 2'd2));
  endfunction

  function automatic logic [63:0] exp_part(logic [63:0] a, logic hv, logic [63:0] p);
    if (exp_fault(a, hv)) return '0;
    if (hv) return (a[63:62] == 2'd1 || a[63:62] == 2'd2) ? p : '0;
    return p;
  endfunction

  function automatic logic [63:0] exp_proc(logic [63:0] a, logic hv, logic [63:0] p);
    if (exp_fault(a, hv)) return '0;
    return (a[63:62] == 2'd0 || (hv && a[63:62] == 2'd1)) ? p : '0;
  endfunction

  task automatic run(logic [63:0] a, logic hv, logic [1:0] k, string tag);
    logic f;
    logic [63:0] ep, eq;
    @(negedge clk);
    ea = a; hv_mode = hv; acc_kind = k; req_valid = 1'b1;
    cur_part = {$urandom, $urandom}; cur_proc = {$urandom, $urandom};
    f = exp_fault(a, hv);
    ep = exp_part(a, hv, cur_part);
    eq = exp_proc(a, hv, cur_proc);
    if (f && k != 2'd2) model_faddr = a;
    @(negedge clk);
    req_valid = 1'b0;
    ea = {$urandom, $urandom};
    chk({"R2 rsp_valid ", tag}, 64'(rsp_valid), 64'd1);
    chk({tag, " part_id"}, part_id, ep);
    chk({tag, " proc_id"}, proc_id, eq);
    chk({tag, " seg_fault"}, 64'(seg_fault), 64'(f));
    chk({"R8 iseg ", tag}, 64'(iseg_fault), 64'(f && k == 2'd2));
    chk({"R9 dseg ", tag}, 64'(dseg_fault), 64'(f && k != 2'd2));
    chk({"R9 R10 fault_addr ", tag}, fault_addr, model_faddr);
  endtask

  initial begin
    #20000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 part_id in reset", part_id, 64'd0);
    chk("R1 fault_addr in reset", fault_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 seg_fault after reset", 64'(seg_fault), 64'd0);
    chk("R1 proc_id after reset", proc_id, 64'd0);

    run(64'h0000_0000_0000_1000, 1'b1, 2'd0, "R4 hv q0");
    run(64'h4000_0000_0000_2000, 1'b1, 2'd1, "R4 hv q1");
    run(64'h8000_0000_0000_3000, 1'b1, 2'd2, "R5 hv q2");
    run(64'hC000_0000_0000_4000, 1'b1, 2'd0, "R5 hv q3");
    run(64'h0000_0000_0000_5000, 1'b0, 2'd2, "R6 guest q0");
    run(64'hC00F_FFFF_FFFF_FFFF, 1'b0, 2'd1, "R6 guest q3");
    run(64'h4000_0000_0000_6000, 1'b0, 2'd0, "R7 guest q1 load");
    run(64'h8000_0000_0000_7000, 1'b0, 2'd2, "R7 guest q2 fetch");
    run(64'h0010_0000_0000_0000, 1'b1, 2'd1, "R3 bit52 store");
    run(64'h2000_0000_0000_0000, 1'b1, 2'd2, "R3 bit61 fetch");
    run(64'h4200_0000_0000_0000, 1'b0, 2'd3, "R3 R7 overlap kind3");
    run(64'h0000_0000_0000_8000, 1'b1, 2'd1, "R10 clean after fault");

    // R2: outputs hold while idle
    @(negedge clk);
    chk("R2 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R2 idle hold part_id", part_id, 64'd0);
    chk("R2 idle hold seg_fault", 64'(seg_fault), 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if ($urandom_range(3) != 0) a[61:52] = '0;
      else a[61:52] = 10'(1) << $urandom_range(9);
      run(a, 1'($urandom), 2'($urandom), "R3-R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule